// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It reads translation descriptors from memory through a single-word read port. The virtual address is split into three fields. The top 12 bits pick an entry in a first-level table, which is aligned to 16 KB. The type code in that entry decides what happens next. A section entry maps a whole 1 MB region, and the walk ends after one read. A table entry points to a second-level table. The middle 8 bits of the virtual address pick an entry there, which maps a 4 KB page. The walk ends after the second read.

The block takes one request at a time. While it is idle, `req_ready` is high. When the walk ends, it pulses `rsp_done` for one cycle and drives the physical address, a fault flag, and the cacheable and bufferable attribute bits of the entry that was used. With translation switched off, the address comes back unchanged and no memory read is made. Each descriptor read is a level request. The block holds the address steady until the memory returns `mem_rd_valid`, so memories of any latency can be attached.

Top module: `xlate_walker`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_done` is 0 and `mem_rd_en` is 0.
- R2: When `xl_enable` is 0 at the accepting edge, the response comes one cycle later with `rsp_paddr` equal to the virtual address, fault 0, both attribute bits 0, and no memory read.
- R3: The first read is at address {`tbl_base`[31:14], vaddr[31:20], 2'b00}; the low 14 bits of `tbl_base` have no effect.
- R4: A first-level descriptor with bits [1:0] = 2'b10 is a section. The walk ends after that one read with paddr = {desc[31:20], vaddr[19:0]}, cacheable = desc[3] and bufferable = desc[2].
- R5: A first-level descriptor with bits [1:0] = 2'b01 starts a second read at {desc[31:10], vaddr[19:12], 2'b00}.
- R6: A second-level descriptor with bit [1] = 1 is a 4 KB page. It gives paddr = {desc[31:12], vaddr[11:0]}, cacheable = desc[3] and bufferable = desc[2].
- R7: A first-level descriptor with bits [1:0] = 2'b00 or 2'b11 ends the walk with a fault after one read. On any fault, `rsp_paddr` is 0 and both attribute bits are 0.
- R8: A second-level descriptor with bits [1:0] = 2'b00 ends the walk with a fault.
- R9: Once raised, `mem_rd_en` stays high and `mem_rd_addr` stays unchanged until `mem_rd_valid` is seen. Exactly one read is made per descriptor, whatever the memory latency.
- R10: `rsp_done` lasts a single cycle. From an accepted request until the end of its `rsp_done`, `req_ready` is 0, and `req_valid` is ignored.
- R11: `xl_enable` is sampled only at the accepting edge. Changing it during a walk does not alter that walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xl_enable | input | 1 | 1: translate; 0: pass the address through |
| tbl_base | input | 32 | First-level table base; bits [31:14] used |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_ready | output | 1 | Walker idle; request accepted when both valid and ready |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| rsp_fault | output | 1 | Translation fault |
| rsp_cacheable | output | 1 | Cacheable attribute of the used entry |
| rsp_bufferable | output | 1 | Bufferable attribute of the used entry |
| mem_rd_en | output | 1 | Descriptor read request, held until served |
| mem_rd_addr | output | 32 | Descriptor word address |
| mem_rd_valid | input | 1 | Read data valid this cycle |
| mem_rd_data | input | 32 | Descriptor word |

## Verification
The checker covers the handshake rules on every cycle:
- the one-cycle completion pulse;
- `req_ready` dropping after a request is accepted;
- the read request held steady until it is served;
- the first-level read address built from the base and the index;
- the one-cycle pass-through when translation is off;
- zeroed outputs on a fault.

Only the bench scenarios can show the following, because they depend on descriptor contents placed in memory:
- which descriptor type codes lead to a section, a page or a fault;
- the second-level address;
- the attribute bits;
- the number of reads made at different memory latencies;
- that requests arriving mid-walk and changes to `xl_enable` mid-walk are ignored.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  parameter int unsigned AW         = 32;
  parameter int unsigned SECT_OFF_W = 20;
  parameter int unsigned PAGE_OFF_W = 12;
  parameter int unsigned WORD_SH    = 2;

  localparam int unsigned L1_IDX_W     = AW - SECT_OFF_W;
  localparam int unsigned L2_IDX_W     = SECT_OFF_W - PAGE_OFF_W;
  localparam int unsigned L1_TBL_ALIGN = L1_IDX_W + WORD_SH;
  localparam int unsigned L2_TBL_ALIGN = L2_IDX_W + WORD_SH;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_FETCH_L1 = 2'd1,
    ST_FETCH_L2 = 2'd2,
    ST_DONE     = 2'd3
  } walk_state_e;

  typedef enum logic [1:0] {
    L1_FAULT   = 2'b00,
    L1_TABLE   = 2'b01,
    L1_SECTION = 2'b10,
    L1_RSVD    = 2'b11
  } l1_kind_e;

  typedef struct packed {
    logic          fault;
    logic          cache;
    logic          buffer;
    logic [AW-1:0] paddr;
  } xlate_res_t;
endpackage

// File: rtl/xlate_rst_sync.sv
module xlate_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/xlate_l1_dec.sv
module xlate_l1_dec
  import xlate_pkg::*;
(
  input  logic [AW-1:0]         desc,
  input  logic [SECT_OFF_W-1:0] va_lo,
  output logic                  is_table,
  output logic [AW-1:0]         l2_addr,
  output xlate_res_t            res
);
  l1_kind_e kind;
  logic     unused_l1;

  assign kind      = l1_kind_e'(desc[1:0]);
  assign unused_l1 = ^desc[L2_TBL_ALIGN-1:4];

  always_comb begin
    res      = '0;
    is_table = 1'b0;
    l2_addr  = {desc[AW-1:L2_TBL_ALIGN], va_lo[SECT_OFF_W-1:PAGE_OFF_W],
                {WORD_SH{1'b0}}};
    case (kind)
      L1_SECTION: begin
        res.paddr  = {desc[AW-1:SECT_OFF_W], va_lo};
        res.cache  = desc[3];
        res.buffer = desc[2];
      end
      L1_TABLE: is_table = 1'b1;
      default:  res.fault = 1'b1;
    endcase
  end
endmodule

// File: rtl/xlate_l2_dec.sv
module xlate_l2_dec
  import xlate_pkg::*;
(
  input  logic [AW-1:0]         desc,
  input  logic [PAGE_OFF_W-1:0] va_pg,
  output xlate_res_t            res
);
  logic unused_l2;
  assign unused_l2 = ^{desc[PAGE_OFF_W-1:4], desc[0]};

  always_comb begin
    res = '0;
    if (desc[1]) begin
      res.paddr  = {desc[AW-1:PAGE_OFF_W], va_pg};
      res.cache  = desc[3];
      res.buffer = desc[2];
    end else begin
      res.fault = 1'b1;
    end
  end
endmodule

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
  import xlate_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  xl_enable,
  input  logic [AW-1:0]         tbl_base,
  input  logic                  req_valid,
  input  logic [AW-1:0]         req_vaddr,
  input  logic                  mem_rd_valid,
  input  logic                  l1_is_table,
  input  logic [AW-1:0]         l1_l2_addr,
  input  xlate_res_t            l1_res,
  input  xlate_res_t            l2_res,
  output logic [SECT_OFF_W-1:0] va_lo,
  output logic                  req_ready,
  output logic                  mem_rd_en,
  output logic [AW-1:0]         mem_rd_addr,
  output logic                  rsp_done,
  output xlate_res_t            rsp_res
);
  walk_state_e           state_q, state_d;
  logic [SECT_OFF_W-1:0] va_q, va_d;
  logic [AW-1:0]         addr_q, addr_d;
  xlate_res_t            res_q, res_d;
  logic                  load_va, load_addr, load_res;
  logic                  unused_base;

  assign unused_base = ^tbl_base[L1_TBL_ALIGN-1:0];

  // next-state and datapath selection
  always_comb begin
    state_d   = state_q;
    va_d      = req_vaddr[SECT_OFF_W-1:0];
    addr_d    = {tbl_base[AW-1:L1_TBL_ALIGN], req_vaddr[AW-1:SECT_OFF_W],
                 {WORD_SH{1'b0}}};
    res_d     = l1_res;
    load_va   = 1'b0;
    load_addr = 1'b0;
    load_res  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          load_va = 1'b1;
          if (xl_enable) begin
            load_addr = 1'b1;
            state_d   = ST_FETCH_L1;
          end else begin
            res_d    = '{fault: 1'b0, cache: 1'b0, buffer: 1'b0, paddr: req_vaddr};
            load_res = 1'b1;
            state_d  = ST_DONE;
          end
        end
      end
      ST_FETCH_L1: begin
        if (mem_rd_valid) begin
          if (l1_is_table) begin
            addr_d    = l1_l2_addr;
            load_addr = 1'b1;
            state_d   = ST_FETCH_L2;
          end else begin
            res_d    = l1_res;
            load_res = 1'b1;
            state_d  = ST_DONE;
          end
        end
      end
      ST_FETCH_L2: begin
        if (mem_rd_valid) begin
          res_d    = l2_res;
          load_res = 1'b1;
          state_d  = ST_DONE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       va_q <= '0;
    else if (load_va) va_q <= va_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         addr_q <= '0;
    else if (load_addr) addr_q <= addr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        res_q <= '0;
    else if (load_res) res_q <= res_d;
  end

  assign va_lo       = va_q;
  assign req_ready   = (state_q == ST_IDLE);
  assign mem_rd_en   = (state_q == ST_FETCH_L1) || (state_q == ST_FETCH_L2);
  assign mem_rd_addr = addr_q;
  assign rsp_done    = (state_q == ST_DONE);
  assign rsp_res     = res_q;
endmodule

// File: rtl/xlate_walker.sv
module xlate_walker
  import xlate_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          xl_enable,
  input  logic [AW-1:0] tbl_base,
  input  logic          req_valid,
  input  logic [AW-1:0] req_vaddr,
  output logic          req_ready,
  output logic          rsp_done,
  output logic [AW-1:0] rsp_paddr,
  output logic          rsp_fault,
  output logic          rsp_cacheable,
  output logic          rsp_bufferable,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_rd_addr,
  input  logic          mem_rd_valid,
  input  logic [AW-1:0] mem_rd_data
);
  logic                  rst_sync_n;
  logic [SECT_OFF_W-1:0] va_lo;
  logic                  l1_is_table;
  logic [AW-1:0]         l1_l2_addr;
  xlate_res_t            l1_res, l2_res, rsp_res;

  xlate_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  xlate_l1_dec i_l1_dec (
    .desc     (mem_rd_data),
    .va_lo    (va_lo),
    .is_table (l1_is_table),
    .l2_addr  (l1_l2_addr),
    .res      (l1_res)
  );

  xlate_l2_dec i_l2_dec (
    .desc  (mem_rd_data),
    .va_pg (va_lo[PAGE_OFF_W-1:0]),
    .res   (l2_res)
  );

  xlate_ctrl i_ctrl (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .xl_enable    (xl_enable),
    .tbl_base     (tbl_base),
    .req_valid    (req_valid),
    .req_vaddr    (req_vaddr),
    .mem_rd_valid (mem_rd_valid),
    .l1_is_table  (l1_is_table),
    .l1_l2_addr   (l1_l2_addr),
    .l1_res       (l1_res),
    .l2_res       (l2_res),
    .va_lo        (va_lo),
    .req_ready    (req_ready),
    .mem_rd_en    (mem_rd_en),
    .mem_rd_addr  (mem_rd_addr),
    .rsp_done     (rsp_done),
    .rsp_res      (rsp_res)
  );

  assign rsp_paddr      = rsp_res.paddr;
  assign rsp_fault      = rsp_res.fault;
  assign rsp_cacheable  = rsp_res.cache;
  assign rsp_bufferable = rsp_res.buffer;
endmodule

// File: rtl/xlate_walker_chk.sv
module xlate_walker_chk
  import xlate_pkg::*;
(
  input logic                       clk,
  input logic                       rst_n,
  input logic                       xl_enable,
  input logic [AW-L1_TBL_ALIGN-1:0] tbl_hi,
  input logic                       req_valid,
  input logic [AW-1:0]              req_vaddr,
  input logic                       req_ready,
  input logic                       rsp_done,
  input logic [AW-1:0]              rsp_paddr,
  input logic                       rsp_fault,
  input logic                       rsp_cacheable,
  input logic                       rsp_bufferable,
  input logic                       mem_rd_en,
  input logic [AW-1:0]              mem_rd_addr,
  input logic                       mem_rd_valid
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_rd_en && !rsp_done));

  a_r2_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !xl_enable) |=>
      (rsp_done && !rsp_fault && rsp_paddr == $past(req_vaddr)));

  a_r3_l1_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && xl_enable) |=>
      (mem_rd_en && mem_rd_addr ==
        {$past(tbl_hi), $past(req_vaddr[AW-1:SECT_OFF_W]), {WORD_SH{1'b0}}}));

  a_r7_fault_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && rsp_fault) |->
      (rsp_paddr == '0 && !rsp_cacheable && !rsp_bufferable));

  a_r9_hold_read: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && !mem_rd_valid) |=> (mem_rd_en && $stable(mem_rd_addr)));

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  a_r10_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
endmodule

bind xlate_walker xlate_walker_chk i_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .xl_enable      (xl_enable),
  .tbl_hi         (tbl_base[xlate_pkg::AW-1:xlate_pkg::L1_TBL_ALIGN]),
  .req_valid      (req_valid),
  .req_vaddr      (req_vaddr),
  .req_ready      (req_ready),
  .rsp_done       (rsp_done),
  .rsp_paddr      (rsp_paddr),
  .rsp_fault      (rsp_fault),
  .rsp_cacheable  (rsp_cacheable),
  .rsp_bufferable (rsp_bufferable),
  .mem_rd_en      (mem_rd_en),
  .mem_rd_addr    (mem_rd_addr),
  .mem_rd_valid   (mem_rd_valid)
);

// File: tb/test_xlate_walker.sv
module test_xlate_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xl_enable = 1'b0;
  logic [31:0] tbl_base = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_ready, rsp_done, rsp_fault, rsp_cacheable, rsp_bufferable;
  logic [31:0] rsp_paddr, mem_rd_addr;
  logic        mem_rd_en;
  logic        mem_rd_valid;
  logic [31:0] mem_rd_data;

  int          checks = 0;
  int          failures = 0;
  int          lat = 0;
  int          lat_cnt;
  int          fetch_cnt = 0;
  logic [31:0] fetch_log [0:3];
  logic [31:0] mem [logic [31:0]];

  logic [31:0] r_paddr;
  logic        r_fault, r_c, r_b;
  int          r_cyc;

  always #5 clk = ~clk;

  xlate_walker i_xlate_walker (
    .clk(clk), .rst_n(rst_n), .xl_enable(xl_enable), .tbl_base(tbl_base),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_ready(req_ready),
    .rsp_done(rsp_done), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .rsp_cacheable(rsp_cacheable), .rsp_bufferable(rsp_bufferable),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data)
  );

  // descriptor memory: answers a held request after lat extra cycles
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rd_valid <= 1'b0;
      mem_rd_data  <= '0;
      lat_cnt      <= 0;
    end else if (mem_rd_valid) begin
      mem_rd_valid <= 1'b0;
    end else if (mem_rd_en) begin
      if (lat_cnt >= lat) begin
        mem_rd_valid <= 1'b1;
        mem_rd_data  <= mem.exists(mem_rd_addr) ? mem[mem_rd_addr] : 32'h0;
        lat_cnt      <= 0;
        if (fetch_cnt < 4) fetch_log[fetch_cnt] = mem_rd_addr;
        fetch_cnt = fetch_cnt + 1;
      end else begin
        lat_cnt <= lat_cnt + 1;
      end
    end else begin
      lat_cnt <= 0;
    end
  end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wait_done();
    r_cyc = 1;
    while (!rsp_done && r_cyc < 300) begin
      @(negedge clk);
      r_cyc++;
    end
    r_paddr = rsp_paddr;
    r_fault = rsp_fault;
    r_c     = rsp_cacheable;
    r_b     = rsp_bufferable;
  endtask

  task automatic do_xlate(input logic [31:0] va);
    @(negedge clk);
    fetch_cnt = 0;
    req_valid = 1'b1;
    req_vaddr = va;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    wait_done();
  endtask

  task automatic t_reset();
    chk("R1 ready", {31'b0, req_ready}, 32'd1);
    chk("R1 done", {31'b0, rsp_done}, 32'd0);
    chk("R1 rd_en", {31'b0, mem_rd_en}, 32'd0);
  endtask

  task automatic t_passthru();
    xl_enable = 1'b0;
    do_xlate(32'h1234_5678);
    chk("R2 paddr", r_paddr, 32'h1234_5678);
    chk("R2 fault/attr", {29'b0, r_fault, r_c, r_b}, 32'd0);
    chk("R2 latency", r_cyc, 32'd1);
    chk("R2 no read", fetch_cnt, 32'd0);
  endtask

  task automatic t_section(input logic [31:0] base, input int l);
    mem.delete();
    lat = l;
    xl_enable = 1'b1;
    tbl_base  = base;
    mem[32'h0010_048C] = 32'h8100_000A;
    do_xlate(32'h1234_5678);
    chk("R3 l1 addr", fetch_log[0], 32'h0010_048C);
    chk("R4 paddr", r_paddr, 32'h8104_5678);
    chk("R4 attr", {30'b0, r_c, r_b}, 32'd2);
    chk("R4 fault", {31'b0, r_fault}, 32'd0);
    chk("R9 one read", fetch_cnt, 32'd1);
  endtask

  task automatic t_page(input logic [31:0] l2d, input logic [1:0] exp_cb);
    mem.delete();
    lat = 1;
    xl_enable = 1'b1;
    tbl_base  = 32'h0020_0000;
    mem[32'h0020_048C] = 32'h0030_0401;
    mem[32'h0030_0514] = l2d;
    do_xlate(32'h1234_5678);
    chk("R5 l1 addr", fetch_log[0], 32'h0020_048C);
    chk("R5 l2 addr", fetch_log[1], 32'h0030_0514);
    chk("R6 paddr", r_paddr, 32'h8188_9678);
    chk("R6 attr", {30'b0, r_c, r_b}, {30'b0, exp_cb});
    chk("R6 fault", {31'b0, r_fault}, 32'd0);
    chk("R9 two reads", fetch_cnt, 32'd2);
  endtask

  task automatic t_l1_fault(input logic [31:0] d);
    mem.delete();
    lat = 0;
    xl_enable = 1'b1;
    tbl_base  = 32'h0040_0000;
    mem[32'h0040_2AF0] = d;
    do_xlate(32'hABC0_0123);
    chk("R7 fault", {31'b0, r_fault}, 32'd1);
    chk("R7 paddr zero", r_paddr, 32'd0);
    chk("R7 attr zero", {30'b0, r_c, r_b}, 32'd0);
    chk("R7 single read", fetch_cnt, 32'd1);
  endtask

  task automatic t_l2_fault();
    mem.delete();
    lat = 2;
    xl_enable = 1'b1;
    tbl_base  = 32'h0020_0000;
    mem[32'h0020_048C] = 32'h0030_0401;
    mem[32'h0030_0514] = 32'hFFFF_FFFC;
    do_xlate(32'h1234_5678);
    chk("R8 fault", {31'b0, r_fault}, 32'd1);
    chk("R8 paddr zero", r_paddr, 32'd0);
    chk("R8 two reads", fetch_cnt, 32'd2);
  endtask

  task automatic t_busy();
    mem.delete();
    lat = 4;
    xl_enable = 1'b1;
    tbl_base  = 32'h0010_0000;
    mem[32'h0010_048C] = 32'h8100_000A;
    mem[32'h0010_0000] = 32'h7700_0006;
    @(negedge clk);
    fetch_cnt = 0;
    req_valid = 1'b1;
    req_vaddr = 32'h1234_5678;
    @(posedge clk);
    @(negedge clk);
    req_vaddr = 32'h0000_0042;
    chk("R10 busy not ready", {31'b0, req_ready}, 32'd0);
    wait_done();
    req_valid = 1'b0;
    chk("R10 first request kept", r_paddr, 32'h8104_5678);
    chk("R10 ready low at done", {31'b0, req_ready}, 32'd0);
    @(negedge clk);
    chk("R10 done single cycle", {31'b0, rsp_done}, 32'd0);
    chk("R10 no extra read", fetch_cnt, 32'd1);
  endtask

  task automatic t_enable_mid();
    mem.delete();
    lat = 3;
    xl_enable = 1'b1;
    tbl_base  = 32'h0010_0000;
    mem[32'h0010_048C] = 32'h8100_000A;
    @(negedge clk);
    fetch_cnt = 0;
    req_valid = 1'b1;
    req_vaddr = 32'h1234_5678;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    xl_enable = 1'b0;
    wait_done();
    chk("R11 walk unchanged", r_paddr, 32'h8104_5678);
    chk("R11 read made", fetch_cnt, 32'd1);
    xl_enable = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_passthru();
    t_section(32'h0010_0000, 0);
    t_section(32'h0010_3FFF, 5);   // R3 low base bits ignored, R9 slow memory
    t_page(32'h8188_9006, 2'b01);
    t_page(32'h8188_900F, 2'b11);
    t_l1_fault(32'hFFFF_FFFC);
    t_l1_fault(32'hFFFF_FFFF);
    t_l2_fault();
    t_busy();
    t_enable_mid();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule